// File: doc/BRIEF.md
# Latched Micro-Step Datapath

This block is the 16-bit data path of a machine whose control unit issues one wide micro-instruction every clock. Sixteen 16-bit registers each have a fixed role, such as program counter, accumulator or instruction register. Two of them are read onto a left and a right source bus. Each bus is frozen in its own latch. A two-way multiplexer sends either the left latch or the memory buffer register to the ALU's left input. The four-function ALU reports negative and zero flags. A combinational shifter follows the ALU, and its result is written back to one chosen register. A memory address register and a memory buffer register connect the block to the memory bus.

A micro-instruction has two parts that act in the same clock. The bus-select fields choose which registers the latches capture at the coming edge. The execute fields (operand select, ALU code, shift code, write-back, MAR and MBR loads) act on the latch contents captured at the previous edge. The controller therefore issues a read one step before the operation that uses it. Because the ALU reads only latches, a register can be both the source and the destination of one step.

Top module: `mstep_datapath`

## Requirements
- R1: While `rst_n` is low and after its release, all sixteen registers, both latches, MAR and MBR are zero. `mem_addr` and `mem_wdata` read 0, and with the all-zero control word `flag_z` is 1 and `flag_n` is 0.
- R2: At each rising edge the left latch takes register `a_sel` and the right latch takes register `b_sel`. The ALU in the next cycle uses these captured values.
- R3: With `amux_sel`=0 the ALU left input is the left latch. With `amux_sel`=1 it is the memory buffer register. The right input is always the right latch.
- R4: `alu_fn` selects the ALU function: 00 gives left+right (modulo 2^16), 01 gives left AND right, 10 passes left, 11 gives NOT left.
- R5: `flag_n` equals bit 15 of the ALU output and `flag_z` is 1 exactly when the ALU output is zero. Both are taken before the shifter and are combinational in the current cycle.
- R6: `sh_fn` 00 passes the ALU output unchanged. 01 shifts it right by one and 10 shifts it left by one, filling with zero in both cases. 11 behaves like 00.
- R7: When `c_we` is 1, register `c_sel` takes the shifter output at the edge. When `c_we` is 0, no register changes. A register read and written in the same step is latched with its value from before the write.
- R8: When `mar_ld` is 1, MAR takes bits 11:0 of the right latch at the edge. Otherwise it holds. `mem_addr` is MAR.
- R9: When `mbr_ld` is 1, MBR takes the shifter output if `mbr_src`=0, or `mem_rdata` if `mbr_src`=1. Otherwise it holds. `mem_wdata` is MBR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| a_sel | input | 4 | Register driven onto the left bus |
| b_sel | input | 4 | Register driven onto the right bus |
| c_sel | input | 4 | Write-back destination register |
| c_we | input | 1 | Write-back enable |
| amux_sel | input | 1 | ALU left operand: 0 left latch, 1 MBR |
| alu_fn | input | 2 | ALU function code |
| sh_fn | input | 2 | Shift code |
| mar_ld | input | 1 | Load MAR from the right latch |
| mbr_ld | input | 1 | Load MBR |
| mbr_src | input | 1 | MBR source: 0 shifter, 1 memory data |
| mem_rdata | input | 16 | Data returned by memory |
| mem_addr | output | 12 | Memory address (MAR) |
| mem_wdata | output | 16 | Memory write data (MBR) |
| flag_n | output | 1 | ALU result negative |
| flag_z | output | 1 | ALU result zero |

## Verification
Register file contents are visible only through the latches, so a corrupted or missed write shows up one step after the read that captures it. It appears in the flags at once, or in `mem_wdata` and `mem_addr` one edge later when the result is parked in MBR or MAR. A latch that captures late, or that sees the post-write value, gives a different ALU result in the very next cycle. Random control words that keep routing results into MBR and MAR expose any such divergence within a few cycles.

// File: rtl/mstep_datapath.sv
module mstep_datapath #(
  parameter int W    = 16,
  parameter int AW   = 12,
  parameter int NREG = 16,
  localparam int SW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [SW-1:0] a_sel,
  input  logic [SW-1:0] b_sel,
  input  logic [SW-1:0] c_sel,
  input  logic          c_we,
  input  logic          amux_sel,
  input  logic [1:0]    alu_fn,
  input  logic [1:0]    sh_fn,
  input  logic          mar_ld,
  input  logic          mbr_ld,
  input  logic          mbr_src,
  input  logic [W-1:0]  mem_rdata,
  output logic [AW-1:0] mem_addr,
  output logic [W-1:0]  mem_wdata,
  output logic          flag_n,
  output logic          flag_z
);
  logic [W-1:0]  rf [NREG];
  logic [W-1:0]  a_lat, b_lat, mbr, opa, alu_y, sh_y;
  logic [AW-1:0] mar;

  assign opa = amux_sel ? mbr : a_lat;

  always_comb begin
    case (alu_fn)
      2'b00:   alu_y = opa + b_lat;
      2'b01:   alu_y = opa & b_lat;
      2'b10:   alu_y = opa;
      default: alu_y = ~opa;
    endcase
  end

  always_comb begin
    case (sh_fn)
      2'b01:   sh_y = {1'b0, alu_y[W-1:1]};
      2'b10:   sh_y = {alu_y[W-2:0], 1'b0};
      default: sh_y = alu_y;
    endcase
  end

  assign flag_n    = alu_y[W-1];
  assign flag_z    = (alu_y == '0);
  assign mem_addr  = mar;
  assign mem_wdata = mbr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_lat <= '0;
      b_lat <= '0;
      mar   <= '0;
      mbr   <= '0;
    end else begin
      a_lat <= rf[a_sel];
      b_lat <= rf[b_sel];
      if (mar_ld) mar <= b_lat[AW-1:0];
      if (mbr_ld) mbr <= mbr_src ? mem_rdata : sh_y;
    end
  end

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n)                         rf[g] <= '0;
      else if (c_we && c_sel == SW'(g))   rf[g] <= sh_y;
    end
  end

  p_mar_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !mar_ld |=> $stable(mem_addr));
  p_mar_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mar_ld |=> mem_addr == $past(b_lat[AW-1:0]));
  p_mbr_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !mbr_ld |=> $stable(mem_wdata));
  p_mbr_mem_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mbr_ld && mbr_src |=> mem_wdata == $past(mem_rdata));
  p_flag_n_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mbr_ld && !mbr_src && (sh_fn == 2'b00) |=> mem_wdata[W-1] == $past(flag_n));
  p_flag_z_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mbr_ld && !mbr_src && (sh_fn == 2'b00) |=> (mem_wdata == '0) == $past(flag_z));
  p_flags_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(flag_n && flag_z));
endmodule

// File: tb/test_mstep_datapath.sv
module test_mstep_datapath;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic [3:0] a_sel = 0, b_sel = 0, c_sel = 0;
  logic c_we = 0, amux_sel = 0, mar_ld = 0, mbr_ld = 0, mbr_src = 0;
  logic [1:0] alu_fn = 0, sh_fn = 0;
  logic [15:0] mem_rdata = 0;
  logic [11:0] mem_addr;
  logic [15:0] mem_wdata;
  logic flag_n, flag_z;

  int n_chk = 0, n_bad = 0;
  logic [15:0] m_rf [16];
  logic [15:0] m_a, m_b, m_mbr;
  logic [11:0] m_mar;

  always #(CLK_PERIOD/2) clk = ~clk;

  mstep_datapath i_mstep_datapath (.*);

  function automatic logic [15:0] f_alu(input logic [15:0] a, b, input logic [1:0] fn);
    case (fn)
      2'b00: return a + b;
      2'b01: return a & b;
      2'b10: return a;
      default: return ~a;
    endcase
  endfunction

  function automatic logic [15:0] f_sh(input logic [15:0] x, input logic [1:0] s);
    if (s == 2'b01) return x >> 1;
    if (s == 2'b10) return x << 1;
    return x;
  endfunction

  task automatic check(input string tag, input logic [15:0] act, exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 16; i++) m_rf[i] = '0;
    m_a = '0; m_b = '0; m_mbr = '0; m_mar = '0;
  endtask

  // one micro-step: drive at negedge, check outputs before the edge, update model at the edge
  task automatic step(input logic [3:0] as, bs, cs, input logic we, am,
                      input logic [1:0] fn, sh, input logic ml, bl, bsrc,
                      input logic [15:0] rd);
    logic [15:0] y, s;
    @(negedge clk);
    a_sel = as; b_sel = bs; c_sel = cs; c_we = we; amux_sel = am;
    alu_fn = fn; sh_fn = sh; mar_ld = ml; mbr_ld = bl; mbr_src = bsrc; mem_rdata = rd;
    #1;
    y = f_alu(am ? m_mbr : m_a, m_b, fn);
    s = f_sh(y, sh);
    check("R3,R4,R5 flag_n", {15'd0, flag_n}, {15'd0, y[15]});
    check("R4,R5 flag_z", {15'd0, flag_z}, {15'd0, y == 16'd0});
    check("R8 mem_addr", {4'd0, mem_addr}, {4'd0, m_mar});
    check("R9 mem_wdata", mem_wdata, m_mbr);
    @(posedge clk);
    if (ml) m_mar = m_b[11:0];
    if (bl) m_mbr = bsrc ? rd : s;
    m_a = m_rf[as];            // R2, R7: latch sees pre-write value
    m_b = m_rf[bs];
    if (we) m_rf[cs] = s;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1931));
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state at the ports
    check("R1 mem_addr", {4'd0, mem_addr}, 16'd0);
    check("R1 mem_wdata", mem_wdata, 16'd0);
    check("R1 flag_z", {15'd0, flag_z}, 16'd1);
    check("R1 flag_n", {15'd0, flag_n}, 16'd0);
    rst_n = 1;

    // R9 memory load, R3 MBR operand, R7 write-back into r4 and r5
    step(0,0,0,0,0,2'b00,2'b00,0,1,1,16'h8001);
    step(0,0,4,1,1,2'b10,2'b00,0,0,0,16'h0);
    step(0,0,0,0,0,2'b00,2'b00,0,1,1,16'h00F3);
    step(0,0,5,1,1,2'b10,2'b00,0,0,0,16'h0);
    // R2 capture r4/r5, R7 c_we=0 leaves registers untouched
    step(4,5,4,0,0,2'b00,2'b00,0,0,0,16'h0);
    // R4 add, R6 left shift, R7 same-step read/write of r4
    step(4,5,4,1,0,2'b00,2'b10,1,1,0,16'h0);
    step(4,4,0,0,0,2'b01,2'b01,1,1,0,16'h0);
    step(4,0,0,0,0,2'b11,2'b11,0,1,0,16'h0);
    // R5 zero result: NOT of all ones
    step(0,0,0,0,0,2'b00,2'b00,0,1,1,16'hFFFF);
    step(0,0,6,1,1,2'b11,2'b00,0,1,0,16'h0);
    step(6,6,0,0,0,2'b10,2'b01,1,0,0,16'h0);
    step(0,0,0,0,0,2'b00,2'b00,0,0,0,16'h0);

    // R2..R9 under random control words with biased memory data
    for (int i = 0; i < 4000; i++) begin
      logic [15:0] rd;
      int k;
      k = $urandom_range(0, 7);
      rd = (k == 0) ? 16'h0000 : (k == 1) ? 16'h8000 : (k == 2) ? 16'hFFFF : 16'($urandom);
      step(4'($urandom), 4'($urandom), 4'($urandom), 1'($urandom), 1'($urandom),
           2'($urandom), 2'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), rd);
    end

    // R1: reset again mid-run clears everything
    @(negedge clk);
    rst_n = 0; c_we = 0; mar_ld = 0; mbr_ld = 0;
    a_sel = 0; b_sel = 0; alu_fn = 0; sh_fn = 0; amux_sel = 0;
    @(posedge clk); @(negedge clk);
    rst_n = 1;
    model_reset();
    check("R1 mem_wdata after reset", mem_wdata, 16'd0);
    check("R1 mem_addr after reset", {4'd0, mem_addr}, 16'd0);
    for (int i = 0; i < 16; i++)
      step(4'(i), 4'(15 - i), 0, 0, 0, 2'b00, 2'b00, 0, 0, 0, 16'h0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule